// File: doc/BRIEF.md
# RAM Bank Power-Gating Controller

This block sits between a CPU bus port and an on-chip RAM built from equal banks (4 KB each by default) placed from address 0x20000000 upward. Software writes a small power-down field that marks upper banks as candidates for shut-off. The lowest bank is never a candidate.

While the core is running, a marked bank is only fenced. Writes to it change nothing, and reads from it return zero with an error pulse. Its contents stay intact, so clearing the field makes the old data visible again. The power enable of a marked bank falls only while the core reports deep sleep and no debugger session is attached. A bank that really lost power returns all ones from every word until that word is written again.

Bus accesses stall while the core is in deep sleep and until every bank has its power back after wake-up. The block models the bank storage and the retention loss. Analog switches and wake sources are outside it.

Top module: `ram_bank_gate`

## Requirements
- R1: Bank k occupies the byte range BASE_ADDR + k·2^(BANK_ADDR_W+2) upward, with word offset taken from address bits [BANK_ADDR_W+1:2]; there are NUM_SEL+1 banks and bank 0 can never be fenced or powered down.
- R2: The power-down field is NUM_SEL bits wide, resets to 0 and is loaded when `cfg_we_i` is high; bit n set marks bank n+1, so 0 marks nothing and all ones (0xF by default) marks every bank except bank 0.
- R3: A write to a marked bank, an unmapped address or a misaligned address leaves every stored word unchanged.
- R4: A read of a marked bank, of an address outside the banks, or of an address with bits [1:0] non-zero is answered in the next cycle with `rvalid_o`=1, `rdata_o`=0 and a single-cycle `err_o`=1.
- R5: Outside deep sleep a marked bank keeps its data; after the field is cleared its earlier contents read back unchanged.
- R6: An accepted read of an unmarked, powered bank returns the stored word in the next cycle with `rvalid_o`=1 and `err_o`=0; an accepted write takes effect for all later reads.
- R7: `bank_pwr_o[n]` (bank n+1) goes low one clock after `deep_sleep_i` rises when bit n of the field is set and `dbg_active_i` is low, and returns high one clock after `deep_sleep_i` falls; banks that are not marked stay powered.
- R8: While `dbg_active_i` is high no bank power enable is low one clock later, so all data survives a deep-sleep period.
- R9: `gnt_o` is low while `deep_sleep_i` is high or any bank power enable is low; a request while `gnt_o` is low is ignored and produces no response.
- R10: After a power loss every word of that bank reads 0xFFFFFFFF until rewritten, while unmarked banks keep their data.
- R11: After reset all bank power enables are high, `rvalid_o` and `err_o` are low, and every word reads 0xFFFFFFFF until first written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Load strobe for the power-down field |
| cfg_pd_i | input | NUM_SEL | New power-down field value |
| deep_sleep_i | input | 1 | Core is in a deep-sleep state |
| dbg_active_i | input | 1 | Debug session attached |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Request is a write |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Write data |
| gnt_o | output | 1 | Request accepted this cycle |
| rvalid_o | output | 1 | Read response valid |
| rdata_o | output | 32 | Read response data |
| err_o | output | 1 | Read response is an error |
| bank_pwr_o | output | NUM_SEL | Power enable of banks 1..NUM_SEL |

## Verification
The bench builds the block with BANK_ADDR_W=4, so each bank holds 16 words and random traffic keeps hitting the same locations, which lets a full shadow copy of the storage track every word across fences and power losses. NUM_SEL keeps its default of 4, so the all-ones field value and every single-bank selection are reachable, and bank index 5 lands just past the last bank to exercise the unmapped path. Deep-sleep periods with and without debug are mixed into the random traffic, so retention and loss follow many different field values.

// File: rtl/ram_gate_pkg.sv
package ram_gate_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 32;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] baddr_t;

    typedef enum logic [1:0] {
        ACC_OK       = 2'd0,
        ACC_FENCED   = 2'd1,
        ACC_UNMAPPED = 2'd2
    } acc_kind_e;

endpackage

// File: rtl/ram_gate_decode.sv
module ram_gate_decode
    import ram_gate_pkg::*;
#(
    parameter int unsigned NUM_BANKS   = 5,
    parameter int unsigned BANK_ADDR_W = 10,
    parameter int unsigned IDX_W       = 3,
    parameter logic [31:0] BASE_ADDR   = 32'h2000_0000
) (
    input  baddr_t                 addr_i,
    input  logic [NUM_BANKS-1:0]   fence_i,
    output logic [IDX_W-1:0]       bank_idx_o,
    output logic [BANK_ADDR_W-1:0] word_idx_o,
    output acc_kind_e              kind_o
);

    localparam int unsigned LO_BANK = BANK_ADDR_W + 2;
    localparam int unsigned HI_CMP  = LO_BANK + IDX_W;

    logic region_hit;
    logic idx_ok;
    logic aligned;

    always_comb begin
        bank_idx_o = addr_i[LO_BANK +: IDX_W];
        word_idx_o = addr_i[2 +: BANK_ADDR_W];
        region_hit = (addr_i[ADDR_W-1:HI_CMP] == BASE_ADDR[ADDR_W-1:HI_CMP]);
        idx_ok     = (32'(bank_idx_o) < NUM_BANKS);
        aligned    = (addr_i[1:0] == 2'b00);
        if (!region_hit || !idx_ok || !aligned) begin
            kind_o = ACC_UNMAPPED;
        end else if (fence_i[bank_idx_o]) begin
            kind_o = ACC_FENCED;
        end else begin
            kind_o = ACC_OK;
        end
    end

endmodule

// File: rtl/ram_gate_power.sv
module ram_gate_power #(
    parameter int unsigned NUM_SEL = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               cfg_we_i,
    input  logic [NUM_SEL-1:0] cfg_pd_i,
    input  logic               deep_sleep_i,
    input  logic               dbg_active_i,
    output logic [NUM_SEL-1:0] sel_o,
    output logic [NUM_SEL-1:0] pwr_o,
    output logic               gnt_o
);

    typedef struct packed {
        logic [NUM_SEL-1:0] sel;
        logic [NUM_SEL-1:0] pwr;
    } pwr_state_t;

    pwr_state_t state_d, state_q;
    logic       true_sleep;

    always_comb begin
        state_d    = state_q;
        true_sleep = deep_sleep_i && !dbg_active_i;
        if (cfg_we_i) begin
            state_d.sel = cfg_pd_i;
        end
        for (int n = 0; n < int'(NUM_SEL); n++) begin
            state_d.pwr[n] = !(state_q.sel[n] && true_sleep);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q.sel <= '0;
            state_q.pwr <= '1;
        end else begin
            state_q <= state_d;
        end
    end

    assign sel_o = state_q.sel;
    assign pwr_o = state_q.pwr;
    assign gnt_o = !deep_sleep_i && (&state_q.pwr);

    for (genvar g = 0; g < NUM_SEL; g++) begin : g_pwr_chk
        // R7
        pwr_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(state_q.pwr[g]) |-> $past(deep_sleep_i && !dbg_active_i && state_q.sel[g]));
    end

    // R8
    dbg_keeps_pwr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dbg_active_i |=> (&pwr_o));

endmodule

// File: rtl/ram_gate_bank.sv
module ram_gate_bank
    import ram_gate_pkg::*;
#(
    parameter int unsigned BANK_ADDR_W = 10
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   pwr_en_i,
    input  logic                   we_i,
    input  logic                   re_i,
    input  logic [BANK_ADDR_W-1:0] addr_i,
    input  word_t                  wdata_i,
    output word_t                  rdata_o
);

    localparam int unsigned WORDS = 1 << BANK_ADDR_W;

    typedef struct packed {
        logic [WORDS-1:0] valid;
        word_t            rdata;
    } bank_state_t;

    bank_state_t state_d, state_q;
    word_t       mem [WORDS];

    always_comb begin
        state_d = state_q;
        if (!pwr_en_i) begin
            state_d.valid = '0;
        end else if (we_i) begin
            state_d.valid[addr_i] = 1'b1;
        end
        if (re_i) begin
            state_d.rdata = state_q.valid[addr_i] ? mem[addr_i] : '1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q.valid <= '0;
            state_q.rdata <= '1;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk_i) begin
        if (we_i && pwr_en_i) begin
            mem[addr_i] <= wdata_i;
        end
    end

    assign rdata_o = state_q.rdata;

    // R9
    we_pwr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i || re_i) |-> pwr_en_i);

endmodule

// File: rtl/ram_bank_gate.sv
module ram_bank_gate
    import ram_gate_pkg::*;
#(
    parameter int unsigned NUM_SEL     = 4,
    parameter int unsigned BANK_ADDR_W = 10,
    parameter logic [31:0] BASE_ADDR   = 32'h2000_0000
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               cfg_we_i,
    input  logic [NUM_SEL-1:0] cfg_pd_i,
    input  logic               deep_sleep_i,
    input  logic               dbg_active_i,
    input  logic               req_i,
    input  logic               we_i,
    input  logic [31:0]        addr_i,
    input  logic [31:0]        wdata_i,
    output logic               gnt_o,
    output logic               rvalid_o,
    output logic [31:0]        rdata_o,
    output logic               err_o,
    output logic [NUM_SEL-1:0] bank_pwr_o
);

    localparam int unsigned NUM_BANKS = NUM_SEL + 1;
    localparam int unsigned IDX_W     = $clog2(NUM_BANKS);

    typedef struct packed {
        logic             rvalid;
        logic             err;
        logic [IDX_W-1:0] ridx;
    } rsp_state_t;

    logic [NUM_SEL-1:0]     sel_q;
    logic [NUM_SEL-1:0]     pwr_q;
    logic [NUM_BANKS-1:0]   fence;
    logic [NUM_BANKS-1:0]   bank_pwr;
    logic [NUM_BANKS-1:0]   bank_we;
    logic [NUM_BANKS-1:0]   bank_re;
    logic [IDX_W-1:0]       bank_idx;
    logic [BANK_ADDR_W-1:0] word_idx;
    acc_kind_e              kind;
    logic                   accept;
    word_t                  bank_rdata [NUM_BANKS];
    rsp_state_t             rsp_d, rsp_q;

    ram_gate_power #(.NUM_SEL(NUM_SEL)) u_power (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .cfg_we_i     (cfg_we_i),
        .cfg_pd_i     (cfg_pd_i),
        .deep_sleep_i (deep_sleep_i),
        .dbg_active_i (dbg_active_i),
        .sel_o        (sel_q),
        .pwr_o        (pwr_q),
        .gnt_o        (gnt_o)
    );

    assign fence    = {sel_q, 1'b0};
    assign bank_pwr = {pwr_q, 1'b1};

    ram_gate_decode #(
        .NUM_BANKS   (NUM_BANKS),
        .BANK_ADDR_W (BANK_ADDR_W),
        .IDX_W       (IDX_W),
        .BASE_ADDR   (BASE_ADDR)
    ) u_decode (
        .addr_i     (addr_i),
        .fence_i    (fence),
        .bank_idx_o (bank_idx),
        .word_idx_o (word_idx),
        .kind_o     (kind)
    );

    always_comb begin
        accept = req_i && gnt_o;
        for (int b = 0; b < int'(NUM_BANKS); b++) begin
            bank_we[b] = accept && we_i  && (kind == ACC_OK) && (32'(bank_idx) == b);
            bank_re[b] = accept && !we_i && (kind == ACC_OK) && (32'(bank_idx) == b);
        end
        rsp_d.rvalid = accept && !we_i;
        rsp_d.err    = accept && !we_i && (kind != ACC_OK);
        rsp_d.ridx   = bank_idx;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        ram_gate_bank #(.BANK_ADDR_W(BANK_ADDR_W)) u_bank (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .pwr_en_i (bank_pwr[g]),
            .we_i     (bank_we[g]),
            .re_i     (bank_re[g]),
            .addr_i   (word_idx),
            .wdata_i  (wdata_i),
            .rdata_o  (bank_rdata[g])
        );
    end

    assign rvalid_o   = rsp_q.rvalid;
    assign err_o      = rsp_q.err;
    assign rdata_o    = (rsp_q.rvalid && !rsp_q.err) ? bank_rdata[rsp_q.ridx] : '0;
    assign bank_pwr_o = pwr_q;

    // R3
    fence_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && we_i && (kind != ACC_OK)) |-> (bank_we == '0));

    // R4
    err_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> $past(req_i && gnt_o && !we_i));

endmodule

// File: tb/ram_bank_gate_test.sv
`timescale 1ns/1ps
module ram_bank_gate_test;

    localparam int NSEL  = 4;
    localparam int NBANK = NSEL + 1;
    localparam int BAW   = 4;
    localparam int WORDS = 1 << BAW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_pd = '0;
    logic        deep = 1'b0;
    logic        dbg = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [31:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        gnt, rvalid, err;
    logic [31:0] rdata;
    logic [3:0]  bank_pwr;

    int total = 0;
    int bad = 0;
    logic [31:0] shadow [NBANK][WORDS];
    logic [3:0]  fld = '0;

    always #4 clk = ~clk;

    ram_bank_gate #(.NUM_SEL(NSEL), .BANK_ADDR_W(BAW)) uut (
        .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_pd_i(cfg_pd),
        .deep_sleep_i(deep), .dbg_active_i(dbg), .req_i(req), .we_i(we),
        .addr_i(addr), .wdata_i(wdata), .gnt_o(gnt), .rvalid_o(rvalid),
        .rdata_o(rdata), .err_o(err), .bank_pwr_o(bank_pwr)
    );

    function automatic logic [31:0] mk_addr(int b, int w);
        return 32'h2000_0000 + 32'(b * (WORDS * 4) + w * 4);
    endfunction

    function automatic bit usable(int b);
        if (b >= NBANK) return 1'b0;
        if (b == 0) return 1'b1;
        return !fld[b-1];
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_cfg(logic [3:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_pd = v;
        @(negedge clk); cfg_we = 1'b0;
        fld = v;
    endtask

    task automatic do_wr(int b, int w, logic [31:0] d);
        @(negedge clk); req = 1'b1; we = 1'b1; addr = mk_addr(b, w); wdata = d;
        @(negedge clk); req = 1'b0; we = 1'b0;
        if (usable(b)) shadow[b][w] = d;
    endtask

    task automatic do_rd_addr(logic [31:0] a, bit exp_err, logic [31:0] exp_d, string tag);
        @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
        @(negedge clk); req = 1'b0;
        chk({tag, " rvalid"}, {31'd0, rvalid}, 32'd1);
        chk({tag, " err"}, {31'd0, err}, {31'd0, exp_err});
        chk({tag, " rdata"}, rdata, exp_d);
    endtask

    task automatic do_rd(int b, int w, string tag);
        if (usable(b)) do_rd_addr(mk_addr(b, w), 1'b0, shadow[b][w], tag);
        else           do_rd_addr(mk_addr(b, w), 1'b1, 32'd0, tag);
    endtask

    task automatic do_sleep(bit with_dbg);
        @(negedge clk); deep = 1'b1; dbg = with_dbg;
        #1 chk("R9 gnt in sleep", {31'd0, gnt}, 32'd0);
        @(negedge clk);
        chk("R7 R8 pwr in sleep", {28'd0, bank_pwr}, with_dbg ? 32'hF : {28'd0, ~fld});
        req = 1'b1; we = 1'b1; addr = mk_addr(0, 0); wdata = 32'hDEAD_BEEF;
        @(negedge clk); req = 1'b0; we = 1'b0; deep = 1'b0;
        #1 chk("R9 gnt after wake", {31'd0, gnt}, {31'd0, (with_dbg || fld == 4'h0)});
        @(negedge clk);
        chk("R7 pwr back", {28'd0, bank_pwr}, 32'hF);
        chk("R9 gnt back", {31'd0, gnt}, 32'd1);
        chk("R9 no stray response", {31'd0, rvalid}, 32'd0);
        dbg = 1'b0;
        if (!with_dbg) begin
            for (int b = 1; b < NBANK; b++)
                if (fld[b-1])
                    for (int w = 0; w < WORDS; w++) shadow[b][w] = 32'hFFFF_FFFF;
        end
    endtask

    initial begin
        #(8 * 200000);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int b = 0; b < NBANK; b++)
            for (int w = 0; w < WORDS; w++) shadow[b][w] = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 rvalid", {31'd0, rvalid}, 32'd0);
        chk("R11 err", {31'd0, err}, 32'd0);
        chk("R11 pwr", {28'd0, bank_pwr}, 32'hF);
        chk("R11 gnt", {31'd0, gnt}, 32'd1);
        do_rd(0, 5, "R11 unwritten word");
        do_rd(3, 9, "R11 unwritten word");

        // R1 R6 decode and plain access
        for (int b = 0; b < NBANK; b++) begin
            do_wr(b, 0, 32'h1000_0000 + 32'(b));
            do_wr(b, WORDS - 1, 32'h2000_0000 + 32'(b));
        end
        for (int b = 0; b < NBANK; b++) begin
            do_rd(b, 0, "R1 R6 first word");
            do_rd(b, WORDS - 1, "R1 R6 last word");
        end

        // R4 unmapped, foreign and misaligned reads
        do_rd(NBANK, 2, "R4 past last bank");
        do_rd_addr(32'h1000_0040, 1'b1, 32'd0, "R4 foreign region");
        do_rd_addr(mk_addr(0, 1) + 32'd2, 1'b1, 32'd0, "R4 misaligned");
        @(negedge clk);
        chk("R4 err single pulse", {31'd0, err}, 32'd0);

        // R2 R3 R5 fence keeps data
        do_wr(2, 3, 32'hAAAA_5555);
        do_cfg(4'h2);
        do_rd(2, 3, "R2 R5 fenced read");
        do_wr(2, 3, 32'h3333_4444);
        do_rd(1, 0, "R2 neighbour bank open");
        do_cfg(4'h0);
        do_rd(2, 3, "R3 R5 data kept after unfence");
        do_cfg(4'hF);
        do_rd(0, 0, "R1 R2 bank0 never fenced");
        do_rd(4, 0, "R2 top bank fenced");
        do_cfg(4'h0);

        // R7 R10 real power loss on banks 1 and 3
        do_wr(1, 4, 32'h0101_0101);
        do_wr(2, 4, 32'h0202_0202);
        do_wr(3, 4, 32'h0303_0303);
        do_cfg(4'h5);
        do_sleep(1'b0);
        do_cfg(4'h0);
        do_rd(1, 4, "R10 bank1 lost");
        do_rd(3, 4, "R10 bank3 lost");
        do_rd(2, 4, "R10 bank2 kept");
        do_rd(0, 0, "R9 write in sleep ignored");

        // R8 debug keeps everything
        do_wr(4, 7, 32'h4444_7777);
        do_cfg(4'hF);
        do_sleep(1'b1);
        do_cfg(4'h0);
        do_rd(4, 7, "R8 kept under debug");

        // random traffic
        for (int i = 0; i < 600; i++) begin
            int op;
            int b;
            int w;
            op = int'($urandom_range(0, 19));
            b  = int'($urandom_range(0, NBANK));
            w  = int'($urandom_range(0, WORDS - 1));
            if (op < 2)       do_cfg(4'($urandom()));
            else if (op < 3)  do_sleep(1'($urandom()));
            else if (op < 11) do_wr(b, w, $urandom());
            else              do_rd(b, w, "R3 R5 R6 R10 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule